// File: doc/BRIEF.md
# CAN Controller Interrupt and Error Capture Unit

This unit sits beside a CAN protocol engine and turns the engine's single-cycle event strobes into a byte-wide interrupt register. Each flag can be enabled or disabled through a mask. The unit also keeps two capture registers:

- one records the kind, direction and frame position of a bus error;
- one records the bit position at which arbitration was lost.

A register read port returns any of the four bytes. Some reads have side effects. A read of the interrupt byte clears the event flags, and a read of a capture byte makes that capture ready for the next event.

The receive flag is not an event. It follows the fill state of the receive FIFO, so reading the interrupt byte does not clear it. Each capture register holds the first event it sees and then ignores later events until software reads it. The interrupt request output tells the host that some enabled flag is pending.

Top module: `can_irq_ctrl`

## Requirements
- R1: The interrupt byte places its flags at these positions: receive at bit 0, transmit done at bit 1, error warning at bit 2, error passive at bit 5, arbitration lost at bit 6, bus error at bit 7. Bits 3 and 4 always read 0.
- R2: Events for the transmit, warning and passive flags set their flag on the clock edge where the strobe is sampled, but only when the matching enable bit is 1. A set flag stays set until the interrupt byte is read. An event whose enable bit is 0 leaves its flag unchanged.
- R3: Reading the interrupt byte (select 0) clears bits 7:1 on that edge and leaves bit 0 unchanged. An event sampled on the same edge as the read still sets its flag.
- R4: Bit 0 of the interrupt byte is, one cycle later, the AND of the receive-FIFO-nonempty input and enable bit 0. It falls only when the FIFO input goes low, or when enable bit 0 is cleared.
- R5: The error capture byte holds the error type in bits 7:6 (0 bit, 1 form, 2 stuff, 3 other), the direction in bit 5 (0 transmit, 1 receive), and the segment code in bits 4:0 (for example 3 start of frame, 8 CRC sequence, 25 ACK slot, 26 end of frame).
- R6: While the error capture is armed, a bus error strobe loads the capture byte, disarms it, and sets bit 7 if that bit is enabled. While it is disarmed, further bus errors change neither the byte nor bit 7. The capture loads even when bit 7 is disabled.
- R7: A read of the error capture byte (select 1) rearms it. A bus error sampled on the same edge as that rearming read is dropped.
- R8: The arbitration capture byte holds the lost bit position in bits 4:0, with the upper bits 0. It follows the same arm, freeze and rearm rules as the error capture. Its read is select 2, and it drives bit 6 of the interrupt byte.
- R9: The enable mask (select 3) is written only while the reset-mode input is 1. Writes made while that input is 0 are ignored. Bits 3 and 4 of the mask always read 0.
- R10: On a read, the selected byte (0 interrupt, 1 error capture, 2 arbitration capture, 3 enable mask) appears on the read data output one cycle later. The value is the one held before that read's side effects. The output holds its value when no read is made.
- R11: The interrupt request output equals, one cycle later, the OR over all bits of the interrupt byte ANDed with the enable mask. Clearing the mask therefore drops the request even while flags remain pending.
- R12: After reset, the interrupt byte, the enable mask, both capture bytes, the read data and the request are all 0, and both captures are armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_reset_mode | input | 1 | Controller is in reset mode; allows mask writes |
| en_wr | input | 1 | Enable mask write strobe |
| en_wdata | input | 8 | Enable mask write value |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 8 | Registered read data |
| rx_fifo_nonempty | input | 1 | Receive FIFO holds at least one frame |
| ev_tx_done | input | 1 | Transmit finished strobe |
| ev_err_warn | input | 1 | Error warning change strobe |
| ev_err_pass | input | 1 | Error passive change strobe |
| ev_arb_lost | input | 1 | Arbitration lost strobe |
| arb_pos | input | ALC_W | Bit position where arbitration was lost |
| ev_bus_err | input | 1 | Bus error strobe |
| berr_type | input | 2 | Bus error type code |
| berr_dir | input | 1 | Bus error direction |
| berr_seg | input | SEG_W | Frame segment code of the bus error |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a rearming capture read that coincides with a new error strobe. The design must drop that event: the read returns the old byte, and neither the capture byte nor bit 7 changes. The stimulus first fills and disarms the capture, then clears the interrupt byte. It then raises the read strobe and the error strobe on the same cycle, and finally sends a fresh error to show that the capture was rearmed. A further sequence fires repeated errors while the capture is frozen, to show that the flag does not come back after an interrupt read.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int INT_W  = 8;
  localparam int B_RX   = 0;
  localparam int B_TX   = 1;
  localparam int B_WARN = 2;
  localparam int B_PASS = 5;
  localparam int B_ARB  = 6;
  localparam int B_BERR = 7;
  // bits that exist in the interrupt byte and the enable mask
  localparam logic [INT_W-1:0] INT_IMPL = 8'hE7;

  typedef enum logic [1:0] {
    SEL_INT = 2'd0,
    SEL_ECC = 2'd1,
    SEL_ALC = 2'd2,
    SEL_EN  = 2'd3
  } rsel_e;
endpackage

// File: rtl/can_irq_capslot.sv
// One first-event capture register: loads once while armed, rearmed by a read.
module can_irq_capslot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ev,
  input  logic [W-1:0] din,
  input  logic         rd_hit,
  output logic [W-1:0] q,
  output logic         armed,
  output logic         hit
);
  assign hit = armed & ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      armed <= 1'b1;
    end else if (armed) begin
      if (ev) begin
        q     <= din;
        armed <= 1'b0;
      end
    end else if (rd_hit) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/can_irq_flags.sv
// Interrupt byte: level-tracking receive bit, sticky event bits cleared by a read.
module can_irq_flags
  import can_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [INT_W-1:0] en,
  input  logic [INT_W-1:0] set,
  input  logic             rx_level,
  input  logic             clr,
  output logic [INT_W-1:0] flags
);
  logic unused_bits;
  assign unused_bits = ^{set & ~INT_IMPL, set[B_RX], en & ~INT_IMPL};

  for (genvar i = 0; i < INT_W; i++) begin : g_bit
    if (i == B_RX) begin : g_rx
      logic b_q;
      always_ff @(posedge clk) begin
        if (rst) b_q <= 1'b0;
        else     b_q <= rx_level & en[i];
      end
      assign flags[i] = b_q;
    end else if (INT_IMPL[i]) begin : g_evt
      logic b_q;
      always_ff @(posedge clk) begin
        if (rst) b_q <= 1'b0;
        else     b_q <= (b_q & ~clr) | (set[i] & en[i]);
      end
      assign flags[i] = b_q;
    end else begin : g_none
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/can_irq_rdport.sv
// Registered byte read port; returns state as it stood before the read's side effects.
module can_irq_rdport
  import can_irq_pkg::*;
#(
  parameter int RD_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  rsel_e           rd_sel,
  input  logic [RD_W-1:0] v_int,
  input  logic [RD_W-1:0] v_ecc,
  input  logic [RD_W-1:0] v_alc,
  input  logic [RD_W-1:0] v_en,
  output logic [RD_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_sel)
        SEL_INT: rd_data <= v_int;
        SEL_ECC: rd_data <= v_ecc;
        SEL_ALC: rd_data <= v_alc;
        default: rd_data <= v_en;
      endcase
    end
  end
endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
  import can_irq_pkg::*;
#(
  parameter int SEG_W = 5,
  parameter int ALC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_reset_mode,
  input  logic             en_wr,
  input  logic [INT_W-1:0] en_wdata,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  output logic [INT_W-1:0] rd_data,
  input  logic             rx_fifo_nonempty,
  input  logic             ev_tx_done,
  input  logic             ev_err_warn,
  input  logic             ev_err_pass,
  input  logic             ev_arb_lost,
  input  logic [ALC_W-1:0] arb_pos,
  input  logic             ev_bus_err,
  input  logic [1:0]       berr_type,
  input  logic             berr_dir,
  input  logic [SEG_W-1:0] berr_seg,
  output logic             irq
);
  localparam int ECC_W = 3 + SEG_W;

  rsel_e            sel;
  logic [INT_W-1:0] en_q, flags_q, set_vec;
  logic [ECC_W-1:0] ecc_q;
  logic [ALC_W-1:0] alc_q;
  logic             ecc_armed, alc_armed, ecc_hit, alc_hit;
  logic             rd_int, rd_ecc, rd_alc;

  assign sel    = rsel_e'(rd_sel);
  assign rd_int = rd_en && (sel == SEL_INT);
  assign rd_ecc = rd_en && (sel == SEL_ECC);
  assign rd_alc = rd_en && (sel == SEL_ALC);

  // enable mask, writable only in reset mode
  always_ff @(posedge clk) begin
    if (rst)                          en_q <= '0;
    else if (en_wr && ctl_reset_mode) en_q <= en_wdata & INT_IMPL;
  end

  can_irq_capslot #(.W(ECC_W)) u_ecc (
    .clk(clk), .rst(rst), .ev(ev_bus_err),
    .din({berr_type, berr_dir, berr_seg}), .rd_hit(rd_ecc),
    .q(ecc_q), .armed(ecc_armed), .hit(ecc_hit)
  );

  can_irq_capslot #(.W(ALC_W)) u_alc (
    .clk(clk), .rst(rst), .ev(ev_arb_lost),
    .din(arb_pos), .rd_hit(rd_alc),
    .q(alc_q), .armed(alc_armed), .hit(alc_hit)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_TX]   = ev_tx_done;
    set_vec[B_WARN] = ev_err_warn;
    set_vec[B_PASS] = ev_err_pass;
    set_vec[B_ARB]  = alc_hit;
    set_vec[B_BERR] = ecc_hit;
  end

  can_irq_flags u_flags (
    .clk(clk), .rst(rst), .en(en_q), .set(set_vec),
    .rx_level(rx_fifo_nonempty), .clr(rd_int), .flags(flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags_q & en_q);
  end

  can_irq_rdport #(.RD_W(INT_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(sel),
    .v_int(flags_q), .v_ecc(INT_W'(ecc_q)), .v_alc(INT_W'(alc_q)), .v_en(en_q),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/can_irq_ctrl_chk.sv
module can_irq_ctrl_chk
  import can_irq_pkg::*;
#(
  parameter int SEG_W = 5,
  parameter int ALC_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_reset_mode,
  input logic             en_wr,
  input logic             rd_en,
  input logic [1:0]       rd_sel,
  input logic             rx_fifo_nonempty,
  input logic             ev_tx_done,
  input logic             ev_err_warn,
  input logic             ev_err_pass,
  input logic             ev_arb_lost,
  input logic             ev_bus_err,
  input logic             irq,
  input logic [INT_W-1:0] en_q,
  input logic [INT_W-1:0] flags_q,
  input logic [2+SEG_W:0] ecc_q,
  input logic [ALC_W-1:0] alc_q,
  input logic             ecc_armed,
  input logic             alc_armed
);
  logic any_ev;
  assign any_ev = ev_tx_done | ev_err_warn | ev_err_pass | ev_arb_lost | ev_bus_err;

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(flags_q & en_q))); // R11

  AST_EN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !ctl_reset_mode |=> $stable(en_q)); // R9

  AST_RX_SURVIVES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == 2'd0 && flags_q[B_RX] && rx_fifo_nonempty && !en_wr) |=> flags_q[B_RX]); // R3

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == 2'd0 && !any_ev) |=> (flags_q[INT_W-1:1] == '0)); // R3

  AST_ECC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!ecc_armed && !(rd_en && rd_sel == 2'd1)) |=> $stable(ecc_q)); // R6

  AST_BERR_NO_RESET: assert property (@(posedge clk) disable iff (rst)
    (!ecc_armed && !flags_q[B_BERR]) |=> !flags_q[B_BERR]); // R6

  AST_ALC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!alc_armed && !(rd_en && rd_sel == 2'd2)) |=> $stable(alc_q)); // R8
endmodule

bind can_irq_ctrl can_irq_ctrl_chk #(.SEG_W(SEG_W), .ALC_W(ALC_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_reset_mode(ctl_reset_mode), .en_wr(en_wr),
  .rd_en(rd_en), .rd_sel(rd_sel), .rx_fifo_nonempty(rx_fifo_nonempty),
  .ev_tx_done(ev_tx_done), .ev_err_warn(ev_err_warn), .ev_err_pass(ev_err_pass),
  .ev_arb_lost(ev_arb_lost), .ev_bus_err(ev_bus_err), .irq(irq),
  .en_q(en_q), .flags_q(flags_q), .ecc_q(ecc_q), .alc_q(alc_q),
  .ecc_armed(ecc_armed), .alc_armed(alc_armed)
);

// File: tb/can_irq_ctrl_bench.sv
module can_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_reset_mode = 1'b0;
  logic       en_wr = 1'b0;
  logic [7:0] en_wdata = 8'h00;
  logic       rd_en = 1'b0;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic       rx_fifo_nonempty = 1'b0;
  logic       ev_tx_done = 1'b0, ev_err_warn = 1'b0, ev_err_pass = 1'b0;
  logic       ev_arb_lost = 1'b0, ev_bus_err = 1'b0;
  logic [4:0] arb_pos = 5'd0;
  logic [1:0] berr_type = 2'd0;
  logic       berr_dir = 1'b0;
  logic [4:0] berr_seg = 5'd0;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  can_irq_ctrl u_can_irq_ctrl (
    .clk(clk), .rst(rst), .ctl_reset_mode(ctl_reset_mode), .en_wr(en_wr),
    .en_wdata(en_wdata), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .rx_fifo_nonempty(rx_fifo_nonempty), .ev_tx_done(ev_tx_done),
    .ev_err_warn(ev_err_warn), .ev_err_pass(ev_err_pass),
    .ev_arb_lost(ev_arb_lost), .arb_pos(arb_pos), .ev_bus_err(ev_bus_err),
    .berr_type(berr_type), .berr_dir(berr_dir), .berr_seg(berr_seg), .irq(irq)
  );

  // behavioural reference model, stepped on each rising edge
  logic [7:0] m_int, m_en, m_ecc, m_alc, m_rd;
  bit         m_ecc_arm, m_alc_arm, m_irq;

  always @(posedge clk) begin
    logic [7:0] nxt;
    if (rst) begin
      m_int = 0; m_en = 0; m_ecc = 0; m_alc = 0; m_rd = 0;
      m_ecc_arm = 1; m_alc_arm = 1; m_irq = 0;
    end else begin
      if (rd_en) begin
        case (rd_sel)
          2'd0: m_rd = m_int;
          2'd1: m_rd = m_ecc;
          2'd2: m_rd = m_alc;
          default: m_rd = m_en;
        endcase
      end
      m_irq = (m_int & m_en) != 8'h00;
      nxt = m_int;
      if (rd_en && rd_sel == 2'd0) nxt = nxt & 8'h01;
      if (ev_tx_done  && m_en[1]) nxt[1] = 1'b1;
      if (ev_err_warn && m_en[2]) nxt[2] = 1'b1;
      if (ev_err_pass && m_en[5]) nxt[5] = 1'b1;
      if (m_alc_arm) begin
        if (ev_arb_lost) begin
          m_alc = {3'b000, arb_pos};
          m_alc_arm = 0;
          if (m_en[6]) nxt[6] = 1'b1;
        end
      end else if (rd_en && rd_sel == 2'd2) m_alc_arm = 1;
      if (m_ecc_arm) begin
        if (ev_bus_err) begin
          m_ecc = {berr_type, berr_dir, berr_seg};
          m_ecc_arm = 0;
          if (m_en[7]) nxt[7] = 1'b1;
        end
      end else if (rd_en && rd_sel == 2'd1) m_ecc_arm = 1;
      nxt[0] = m_en[0] & rx_fifo_nonempty;
      m_int = nxt;
      if (en_wr && ctl_reset_mode) m_en = en_wdata & 8'hE7;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      tests++;
      if (rd_data !== m_rd) begin
        fails++;
        $display("FAIL R10 per-cycle rd_data: actual %h expected %h", rd_data, m_rd);
      end
      tests++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL R11 per-cycle irq: actual %b expected %b", irq, m_irq);
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; rd_sel = s;
    @(negedge clk); rd_en = 1'b0;
    check(tag, rd_data, exp);
  endtask

  task automatic write_en(input logic [7:0] v, input bit mode);
    @(negedge clk); ctl_reset_mode = mode; en_wr = 1'b1; en_wdata = v;
    @(negedge clk); en_wr = 1'b0; ctl_reset_mode = 1'b0;
  endtask

  task automatic pulse_tx();
    @(negedge clk); ev_tx_done = 1'b1;
    @(negedge clk); ev_tx_done = 1'b0;
  endtask

  task automatic pulse_err(input logic [1:0] t, input logic d, input logic [4:0] s);
    @(negedge clk); ev_bus_err = 1'b1; berr_type = t; berr_dir = d; berr_seg = s;
    @(negedge clk); ev_bus_err = 1'b0;
  endtask

  task automatic pulse_arb(input logic [4:0] p);
    @(negedge clk); ev_arb_lost = 1'b1; arb_pos = p;
    @(negedge clk); ev_arb_lost = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R10 watchdog expired: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 reset rd_data", rd_data, 8'h00);
    check("R12 reset irq", {7'd0, irq}, 8'h00);
    rd(2'd3, 8'h00, "R12 reset enable mask");
    rd(2'd0, 8'h00, "R12 reset interrupt byte");

    write_en(8'hFF, 1'b0);
    rd(2'd3, 8'h00, "R9 mask write outside reset mode ignored");
    write_en(8'hFF, 1'b1);
    rd(2'd3, 8'hE7, "R9 R1 mask write in reset mode");

    pulse_tx();
    rd(2'd0, 8'h02, "R2 transmit flag set");
    rd(2'd0, 8'h00, "R3 flags cleared by read");
    @(negedge clk); ev_err_warn = 1'b1; ev_err_pass = 1'b1;
    @(negedge clk); ev_err_warn = 1'b0; ev_err_pass = 1'b0;
    rd(2'd0, 8'h24, "R1 warning and passive positions");

    rx_fifo_nonempty = 1'b1;
    @(negedge clk);
    rd(2'd0, 8'h01, "R4 receive flag follows FIFO");
    rd(2'd0, 8'h01, "R3 receive flag survives read");
    rx_fifo_nonempty = 1'b0;
    @(negedge clk);
    rd(2'd0, 8'h00, "R4 receive flag drops with FIFO");

    pulse_err(2'd2, 1'b1, 5'd8);
    pulse_err(2'd0, 1'b0, 5'd3);
    rd(2'd0, 8'h80, "R6 bus error flag set");
    pulse_err(2'd1, 1'b0, 5'd25);
    rd(2'd0, 8'h00, "R6 frozen capture sets no flag");
    rd(2'd1, 8'hA8, "R5 R6 first error kept");
    pulse_err(2'd3, 1'b0, 5'd26);
    rd(2'd0, 8'h80, "R7 rearmed capture flags again");
    rd(2'd1, 8'hDA, "R5 other/tx/end-of-frame code");

    pulse_err(2'd1, 1'b1, 5'd25);
    rd(2'd0, 8'h80, "R6 capture after rearm");
    @(negedge clk); rd_en = 1'b1; rd_sel = 2'd1;
    ev_bus_err = 1'b1; berr_type = 2'd0; berr_dir = 1'b0; berr_seg = 5'd3;
    @(negedge clk); rd_en = 1'b0; ev_bus_err = 1'b0;
    check("R7 read with coincident error returns old", rd_data, 8'h79);
    rd(2'd0, 8'h00, "R7 coincident error dropped");
    pulse_err(2'd2, 1'b0, 5'd9);
    rd(2'd1, 8'h89, "R7 capture rearmed after read");

    pulse_arb(5'd17);
    pulse_arb(5'd5);
    rd(2'd0, 8'hC0, "R8 arbitration flag set");
    rd(2'd2, 8'h11, "R8 first position kept");
    pulse_arb(5'd31);
    rd(2'd2, 8'h1F, "R8 position after rearm");

    rd(2'd0, 8'h40, "R8 arbitration flag after rearm");
    pulse_tx();
    @(negedge clk);
    check("R11 request raised", {7'd0, irq}, 8'h01);
    write_en(8'h00, 1'b1);
    @(negedge clk);
    check("R11 request drops with mask cleared", {7'd0, irq}, 8'h00);
    rd(2'd0, 8'h02, "R11 flag still pending");
    pulse_tx();
    rd(2'd0, 8'h00, "R2 disabled event sets nothing");
    pulse_err(2'd3, 1'b1, 5'd8);
    rd(2'd1, 8'hE8, "R6 capture loads while disabled");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule